// File: doc/BRIEF.md
# Bias-Relative Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Each lookup brings a branch address and a one-bit static bias that travels with the branch and names the direction the branch usually takes. The table does not store directions. Each table entry is a small saturating counter. It records whether branches that map to it tend to follow their bias or go against it. Two branches that share an entry and are both well biased strengthen the same "follow the bias" state, even when their biases point in opposite directions. Sharing an entry therefore costs far less accuracy than it would in a table of direction counters.

The table index is the branch word address XOR a global history of resolved outcomes. This spreads correlated branches over the table. The lookup returns the prediction and the index it used in the same cycle. The pipeline carries that index, together with the bias, to the update port. When the branch resolves, the update port trains the counter at that index and shifts the outcome into the history. Producing the bias bits, predicting targets and recovering from flushes are left to the surrounding pipeline.

Top module: `agree_predictor`

## Requirements
- R1: After synchronous reset every counter holds 2 (weakly follow the bias) and the history is zero, so every lookup predicts its own bias bit.
- R2: A counter value of 2 or 3 means "follow": pred_taken equals lk_bias. A value of 0 or 1 means "oppose": pred_taken is the inverse of lk_bias.
- R3: An update whose outcome equals its bias adds one to the counter at upd_idx, stopping at 3.
- R4: An update whose outcome differs from its bias subtracts one from the counter at upd_idx, stopping at 0.
- R5: pred_idx equals lk_pc bits [ALIGN_W+IDX_W-1:ALIGN_W] XOR the history, in the same cycle as the lookup.
- R6: Each update shifts the history one place toward the MSB and puts upd_taken in bit 0, at the clock edge that writes the counter.
- R7: A lookup that hits the entry being updated in the same cycle sees the counter value from before that update.
- R8: A cycle with upd_valid low changes no counter and no history bit, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_bias | input | 1 | Static bias of that branch (1 = taken) |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_idx | output | IDX_W | Table index used by this lookup, to be returned at update |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_idx | input | IDX_W | Index recorded at lookup time |
| upd_bias | input | 1 | Bias bit of the resolved branch |
| upd_taken | input | 1 | Resolved direction (1 = taken) |

## Verification
pred_taken and pred_idx are combinational in the lookup cycle. They reflect counters and history as they stood after the last rising edge. An update becomes visible at the first lookup after the next rising edge. The bench drives inputs on the falling edge and compares both outputs 1 ns later against a behavioural model. It advances that model only after the rising edge. In this way, an update and a lookup in the same cycle are checked for returning the old value. Lookups aimed at specific entries compute their address from the model's history, so saturation, bias inversion and ignored strobes are all observed through pred_taken.

// File: rtl/agree_pkg.sv
package agree_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_MAX  = '1;
  localparam ctr_t CTR_INIT = ctr_t'(1 << (CTR_W - 1));

  function automatic ctr_t ctr_step(input ctr_t c, input logic follow);
    ctr_t r;
    if (follow) r = (c == CTR_MAX) ? c : c + ctr_t'(1);
    else        r = (c == '0)      ? c : c - ctr_t'(1);
    return r;
  endfunction

  function automatic logic ctr_follows(input ctr_t c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/agree_hash.sv
module agree_hash #(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 10
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [IDX_W-1:0] hist,
  output logic [IDX_W-1:0] idx
);
  localparam int HI = ALIGN_W + IDX_W;
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[PC_W-1:HI], pc[ALIGN_W-1:0]};
  assign idx = pc[ALIGN_W +: IDX_W] ^ hist;
endmodule

// File: rtl/agree_history.sv
module agree_history #(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
  end

  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (hist[0] == $past(bit_in)) && (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));
  assert_hist_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist));
endmodule

// File: rtl/agree_table.sv
module agree_table
  import agree_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_follow
);
  localparam int DEPTH = 1 << IDX_W;
  ctr_t [DEPTH-1:0] ctr_mem;

  assign rd_ctr = ctr_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      ctr_mem[wr_idx] <= ctr_step(ctr_mem[wr_idx], wr_follow);
    end
  end

  assert_follow_up_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_follow) |=> ctr_mem[$past(wr_idx)] >= $past(ctr_mem[wr_idx]));
  assert_oppose_down_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_follow) |=> ctr_mem[$past(wr_idx)] <= $past(ctr_mem[wr_idx]));
  assert_idle_keep_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ctr_mem));
endmodule

// File: rtl/agree_predictor.sv
module agree_predictor
  import agree_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ALIGN_W = 2,
  parameter int IDX_W   = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic             lk_bias,
  output logic             pred_taken,
  output logic [IDX_W-1:0] pred_idx,
  input  logic             upd_valid,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_bias,
  input  logic             upd_taken
);
  localparam int HIST_W = IDX_W;

  logic [HIST_W-1:0] hist;
  ctr_t              lk_ctr;
  logic              upd_follow;

  assign upd_follow = (upd_taken == upd_bias);

  agree_hash #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u_hash (
    .pc(lk_pc), .hist(hist), .idx(pred_idx));

  agree_history #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .shift_en(upd_valid), .bit_in(upd_taken), .hist(hist));

  agree_table #(.IDX_W(IDX_W)) u_tab (
    .clk(clk), .rst(rst), .rd_idx(pred_idx), .rd_ctr(lk_ctr),
    .wr_en(upd_valid), .wr_idx(upd_idx), .wr_follow(upd_follow));

  assign pred_taken = ctr_follows(lk_ctr) ? lk_bias : ~lk_bias;

  assert_reset_bias_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> pred_taken == lk_bias);
endmodule

// File: tb/sim_agree_predictor.sv
`timescale 1ns/1ps
module sim_agree_predictor;
  localparam int PC_W = 32, ALIGN_W = 2, IDX_W = 10;
  localparam int DEPTH = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst;
  logic [PC_W-1:0]  lk_pc;
  logic             lk_bias;
  logic             pred_taken;
  logic [IDX_W-1:0] pred_idx;
  logic             upd_valid;
  logic [IDX_W-1:0] upd_idx;
  logic             upd_bias;
  logic             upd_taken;

  always #2 clk = ~clk;

  agree_predictor #(.PC_W(PC_W), .ALIGN_W(ALIGN_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_bias(lk_bias),
    .pred_taken(pred_taken), .pred_idx(pred_idx), .upd_valid(upd_valid),
    .upd_idx(upd_idx), .upd_bias(upd_bias), .upd_taken(upd_taken));

  int checks = 0;
  int fails  = 0;
  int m_ctr[DEPTH];
  int m_hist;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [PC_W-1:0] pc_for(input int idx);
    return PC_W'(((idx ^ m_hist) & (DEPTH - 1)) << ALIGN_W);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_ctr[i] = 2;
    m_hist = 0;
  endtask

  // one cycle: drive, compare, then advance model after the edge
  task automatic step(input string tag, input logic [PC_W-1:0] pc, input logic b,
                      input logic uv, input int ui, input logic ub, input logic ut);
    int e_idx, e_pred;
    @(negedge clk);
    lk_pc = pc; lk_bias = b;
    upd_valid = uv; upd_idx = IDX_W'(ui); upd_bias = ub; upd_taken = ut;
    #1;
    e_idx  = ((int'(pc) >> ALIGN_W) & (DEPTH - 1)) ^ m_hist;
    e_pred = (m_ctr[e_idx] >= 2) ? int'(b) : int'(!b);
    check("R5 index", int'(pred_idx), e_idx);
    check(tag, int'(pred_taken), e_pred);
    @(posedge clk);
    if (uv) begin
      if (ut == ub) begin if (m_ctr[ui] < 3) m_ctr[ui]++; end
      else          begin if (m_ctr[ui] > 0) m_ctr[ui]--; end
      m_hist = ((m_hist << 1) | int'(ut)) & (DEPTH - 1);
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; lk_pc = '0; lk_bias = 1'b0;
    upd_valid = 1'b0; upd_idx = '0; upd_bias = 1'b0; upd_taken = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: fresh table follows the bias in both polarities
    step("R1 reset bias0", pc_for(5), 1'b0, 0, 0, 0, 0);
    step("R1 reset bias1", pc_for(900), 1'b1, 0, 0, 0, 0);

    // R4 and R2: drive entry 7 to 0 through oppose updates (history moves too)
    for (int k = 0; k < 4; k++) step("R4 oppose", pc_for(7), 1'b1, 1, 7, 1, 0);
    step("R2 oppose inverts bias1", pc_for(7), 1'b1, 0, 0, 0, 0);
    step("R2 oppose inverts bias0", pc_for(7), 1'b0, 0, 0, 0, 0);
    // R3: climb back and saturate, then one oppose stays in follow
    for (int k = 0; k < 6; k++) step("R3 follow", pc_for(7), 1'b0, 1, 7, 0, 0);
    step("R3 saturated", pc_for(7), 1'b1, 1, 7, 1, 0);
    step("R3 after sat-1", pc_for(7), 1'b1, 0, 0, 0, 0);

    // R7: lookup and update hitting the same entry in one cycle
    step("R4 to 1", pc_for(7), 1'b0, 1, 7, 1, 0);
    step("R7 same-cycle old value", pc_for(7), 1'b1, 1, 7, 0, 1);
    step("R7 value after update", pc_for(7), 1'b1, 0, 0, 0, 0);

    // R6: history fills with a known pattern; index moves accordingly
    for (int k = 0; k < 12; k++) step("R6 history", PC_W'(k * 4), 1'b1, 1, 100, 1, 1'(k & 1));
    step("R6 history index", PC_W'(32'h40), 1'b0, 0, 0, 0, 0);

    // R8: strobe low with busy update fields changes nothing
    for (int k = 0; k < 8; k++) step("R8 idle", pc_for(7), 1'b1, 0, 7, 1, 0);
    step("R8 entry untouched", pc_for(7), 1'b0, 0, 0, 0, 0);

    // mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      int ui;
      ui = $urandom_range(0, 15);
      step("R2 mixed", PC_W'($urandom), 1'($urandom), 1'($urandom), ui,
           1'($urandom), 1'($urandom));
    end

    // R1 again after a mid-run reset
    @(negedge clk); rst = 1'b1; upd_valid = 1'b0;
    @(posedge clk); model_reset();
    @(negedge clk); rst = 1'b0;
    step("R1 re-reset", pc_for(7), 1'b0, 0, 0, 0, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule